// File: doc/BRIEF.md
# Dual-buffer Ethernet transmit controller

This block is the transmit side of a compact memory-mapped Ethernet MAC. Software reaches it through a 32-bit register bus that moves whole words only. It holds two frame buffers. Each buffer has its own length word and its own control word. To send, software fills a buffer with frame bytes, writes the byte count, and then writes a command into that buffer's control word. The controller then streams the bytes out on a byte interface with valid, last and ready. A second command uses the same buffer to load the 48-bit station address instead of sending a frame.

The command bits in a control word clear themselves. Start reads as 1 only while a frame is queued or on the wire, so software polls that bit to learn when a buffer is free. While one buffer is sending, software can arm the other buffer, and its frame follows directly after. When a command finishes, a single-cycle interrupt pulse is raised if two conditions hold: the buffer's interrupt-enable bit is set, and bit 31 of the global enable word is set.

Top module: `eth_tx_ctrl`

## Requirements
- R1: After reset, both control words, both length words, the global enable word and `station_mac` are zero, and `irq` and `tx_valid` are low.
- R2: Word addresses are `{b, off}`, with b the buffer and off a 9-bit offset. Offsets 0..508 are data words, 509 is the length, 511 is control, and offset 510 of buffer 0 is the global enable. Offset 510 of buffer 1 reads 0 and ignores writes. `bus_rdata` returns the addressed word on the cycle after `bus_rd`.
- R3: The control word uses bit 0 as Start, bit 1 as Program and bit 3 as interrupt-enable. With {Program,Start} = 01 the buffer is sent. With 11 the station address is loaded. With 00 or 10 the value is only stored.
- R4: A send emits exactly length bytes. Byte k is bits [8*(k%4)+7 : 8*(k%4)] of data word k/4, and `tx_last` is high only on the final byte.
- R5: While `tx_valid` is high and `tx_ready` is low, `tx_data`, `tx_valid` and `tx_last` hold.
- R6: A load command sets `station_mac[8k+7:8k]` to byte k of the buffer (k = 0..5) on the cycle after the write, and emits no frame bytes. No other write changes `station_mac`.
- R7: Control reads return the stored bits with bit 1 at 0. Bit 0 reads 1 while that buffer's frame is pending or being sent, and 0 otherwise. All other bits read as written.
- R8: A control write to a buffer whose Start bit reads 1 is ignored. The word is unchanged, no command runs, and no extra frame follows.
- R9: A send with length 0 finishes at once. It emits no bytes, Start reads 0 afterwards, and the interrupt rule still applies.
- R10: `irq` is high for one cycle after a command finishes, and only if the interrupt-enable bit of the control value written with the command is set and global enable bit 31 is set. A load or a zero-length send finishes at its write edge. A send finishes at its final handshaked byte.
- R11: A buffer armed while the other is sending is queued: Start reads 1. Its frame begins after the first frame's last byte, with `tx_valid` low for exactly one cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Word write strobe |
| bus_rd | input | 1 | Word read strobe |
| bus_addr | input | 10 | Word address {buffer, offset} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after `bus_rd` |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte valid |
| tx_last | output | 1 | Final byte of the frame |
| tx_ready | input | 1 | Sink accepts the byte |
| station_mac | output | 48 | Station address, byte 0 in bits 7:0 |
| irq | output | 1 | Single-cycle completion interrupt |

## Verification
The assertions rely on a few things the bus master must respect. It never writes a buffer's data words while that buffer's frame is streaming, because the hold check on `tx_data` would fail if the bytes underneath it changed. It also never asserts `bus_wr` and `bus_rd` in the same cycle. The directed tasks follow both rules: every buffer is filled and its length written before the command, and the next buffer is loaded only after the previous frame has been captured in full. Sink back-pressure is driven from a ready pattern that the bench sets per scenario. The hold and gap properties are therefore exercised under stalled, alternating and always-ready sinks.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

    localparam int NUM_BUF     = 2;
    localparam int CTRL_S_BIT  = 0;
    localparam int CTRL_P_BIT  = 1;
    localparam int CTRL_I_BIT  = 3;
    localparam int GIE_EN_BIT  = 31;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_SEND = 2'd1,
        CMD_PROG = 2'd2
    } cmd_e;

    typedef enum logic [2:0] {
        SLOT_DATA,
        SLOT_LEN,
        SLOT_GIE,
        SLOT_CTRL,
        SLOT_NONE
    } slot_e;

    typedef struct packed {
        logic  bsel;
        slot_e slot;
    } slot_t;

    // Map the two command bits of a control value to an operation
    function automatic cmd_e decode_cmd(input logic [31:0] v);
        case ({v[CTRL_P_BIT], v[CTRL_S_BIT]})
            2'b01:   return CMD_SEND;
            2'b11:   return CMD_PROG;
            default: return CMD_NONE;
        endcase
    endfunction

    // Select one byte lane of a word, lane 0 = least significant
    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        return w[{lane, 3'b000} +: 8];
    endfunction

endpackage

// File: rtl/eth_tx_bufmem.sv
module eth_tx_bufmem #(
    parameter int BUF_AW = 9
) (
    input  logic              clk,
    input  logic              we,
    input  logic [BUF_AW:0]   waddr,
    input  logic [31:0]       wdata,
    input  logic [BUF_AW:0]   bus_raddr,
    output logic [31:0]       bus_rdata_w,
    input  logic [BUF_AW:0]   st_raddr,
    output logic [31:0]       st_rdata,
    input  logic              mac_sel,
    output logic [31:0]       mac_w0,
    output logic [15:0]       mac_w1
);
    localparam int WORDS = 2 * (2 ** BUF_AW);

    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign bus_rdata_w = mem[bus_raddr];
    assign st_rdata    = mem[st_raddr];
    assign mac_w0      = mem[{mac_sel, {BUF_AW{1'b0}}}];
    assign mac_w1      = mem[{mac_sel, {(BUF_AW-1){1'b0}}, 1'b1}][15:0];

endmodule

// File: rtl/eth_tx_regs.sv
module eth_tx_regs
    import eth_tx_pkg::*;
#(
    parameter int BUF_AW = 9,
    parameter int LEN_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          bus_wr,
    input  logic                          bus_rd,
    input  logic [BUF_AW:0]               bus_addr,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    output logic                          mem_we,
    input  logic [31:0]                   mem_rdata,
    input  logic [31:0]                   mac_w0,
    input  logic [15:0]                   mac_w1,
    output logic [NUM_BUF-1:0]            pend_set,
    input  logic [NUM_BUF-1:0]            busy,
    output logic [NUM_BUF-1:0][LEN_W-1:0] len_q,
    input  logic                          tx_done,
    input  logic                          done_buf,
    output logic [47:0]                   station_mac,
    output logic                          irq
);
    localparam int DEPTH = 2 ** BUF_AW;
    localparam logic [BUF_AW-1:0] LEN_OFS  = BUF_AW'(DEPTH - 3);
    localparam logic [BUF_AW-1:0] GIE_OFS  = BUF_AW'(DEPTH - 2);
    localparam logic [BUF_AW-1:0] CTRL_OFS = BUF_AW'(DEPTH - 1);

    slot_t                     acc;
    logic [BUF_AW-1:0]         off;
    logic [NUM_BUF-1:0][31:0]  ctrl_q;
    logic [31:0]               gie_q;
    cmd_e                      wr_cmd;
    logic                      ctrl_wr;
    logic                      zero_len;
    logic                      irq_req;

    // Address decode
    always_comb begin
        off      = bus_addr[BUF_AW-1:0];
        acc.bsel = bus_addr[BUF_AW];
        if (off == LEN_OFS)       acc.slot = SLOT_LEN;
        else if (off == GIE_OFS)  acc.slot = acc.bsel ? SLOT_NONE : SLOT_GIE;
        else if (off == CTRL_OFS) acc.slot = SLOT_CTRL;
        else                      acc.slot = SLOT_DATA;
    end

    assign wr_cmd   = decode_cmd(bus_wdata);
    assign ctrl_wr  = bus_wr && (acc.slot == SLOT_CTRL) && !busy[acc.bsel];
    assign zero_len = (len_q[acc.bsel] == '0);
    assign mem_we   = bus_wr && (acc.slot == SLOT_DATA);

    always_comb begin
        for (int b = 0; b < NUM_BUF; b++) begin
            pend_set[b] = ctrl_wr && (acc.bsel == 1'(b)) && (wr_cmd == CMD_SEND) && !zero_len;
        end
    end

    // Completion events: immediate commands at the write edge, sends at the final byte
    assign irq_req = (ctrl_wr && bus_wdata[CTRL_I_BIT] &&
                      ((wr_cmd == CMD_PROG) || ((wr_cmd == CMD_SEND) && zero_len)))
                   || (tx_done && ctrl_q[done_buf][CTRL_I_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            len_q       <= '0;
            gie_q       <= '0;
            station_mac <= '0;
            irq         <= 1'b0;
        end else begin
            if (bus_wr && (acc.slot == SLOT_LEN)) len_q[acc.bsel] <= bus_wdata[LEN_W-1:0];
            if (bus_wr && (acc.slot == SLOT_GIE)) gie_q <= bus_wdata;
            if (ctrl_wr) ctrl_q[acc.bsel] <= bus_wdata & ~32'h3;
            if (ctrl_wr && (wr_cmd == CMD_PROG)) station_mac <= {mac_w1, mac_w0};
            irq <= irq_req && gie_q[GIE_EN_BIT];
        end
    end

    // Registered read port
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (acc.slot)
                SLOT_DATA: bus_rdata <= mem_rdata;
                SLOT_LEN:  bus_rdata <= 32'(len_q[acc.bsel]);
                SLOT_GIE:  bus_rdata <= gie_q;
                SLOT_CTRL: bus_rdata <= ctrl_q[acc.bsel] | {31'b0, busy[acc.bsel]};
                default:   bus_rdata <= '0;
            endcase
        end
    end

    AST_MAC_ONLY_BY_LOAD: assert property (@(posedge clk) disable iff (rst)
        !(ctrl_wr && (wr_cmd == CMD_PROG)) |=> $stable(station_mac)); // R6

    AST_IRQ_NEEDS_EVENT: assert property (@(posedge clk) disable iff (rst)
        !(bus_wr || tx_done) |=> !irq); // R10

endmodule

// File: rtl/eth_tx_stream.sv
module eth_tx_stream
    import eth_tx_pkg::*;
#(
    parameter int BUF_AW = 9,
    parameter int LEN_W  = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_BUF-1:0]            pend_set,
    input  logic [NUM_BUF-1:0][LEN_W-1:0] len_q,
    output logic [NUM_BUF-1:0]            busy,
    output logic [BUF_AW:0]               st_raddr,
    input  logic [31:0]                   st_rdata,
    output logic [7:0]                    tx_data,
    output logic                          tx_valid,
    output logic                          tx_last,
    input  logic                          tx_ready,
    output logic                          tx_done,
    output logic                          done_buf
);
    logic [NUM_BUF-1:0] pend;
    logic               active;
    logic               cur;
    logic [LEN_W-1:0]   ptr;
    logic [LEN_W-1:0]   last_idx;
    logic               starting;
    logic               start_buf;
    logic [NUM_BUF-1:0] start_mask;
    logic               hs;

    assign starting  = !active && (pend != '0);
    assign start_buf = pend[0] ? 1'b0 : 1'b1;

    always_comb begin
        for (int b = 0; b < NUM_BUF; b++) begin
            start_mask[b] = starting && (start_buf == 1'(b));
            busy[b]       = pend[b] || (active && (cur == 1'(b)));
        end
    end

    assign tx_valid = active;
    assign tx_last  = active && (ptr == last_idx);
    assign hs       = tx_valid && tx_ready;
    assign tx_done  = hs && tx_last;
    assign done_buf = cur;
    assign st_raddr = {cur, ptr[BUF_AW+1:2]};
    assign tx_data  = pick_byte(st_rdata, ptr[1:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            active   <= 1'b0;
            cur      <= 1'b0;
            ptr      <= '0;
            last_idx <= '0;
        end else begin
            pend <= (pend | pend_set) & ~start_mask;
            if (starting) begin
                active   <= 1'b1;
                cur      <= start_buf;
                ptr      <= '0;
                last_idx <= len_q[start_buf] - LEN_W'(1);
            end else if (hs) begin
                if (tx_last) active <= 1'b0;
                else         ptr    <= ptr + LEN_W'(1);
            end
        end
    end

    AST_NO_CMD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (pend_set & busy) == '0); // R8

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last))); // R5

    AST_GAP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && tx_ready && tx_last) |=> !tx_valid); // R11

endmodule

// File: rtl/eth_tx_ctrl.sv
module eth_tx_ctrl
    import eth_tx_pkg::*;
#(
    parameter int BUF_AW = 9,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [BUF_AW:0]   bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_data,
    output logic              tx_valid,
    output logic              tx_last,
    input  logic              tx_ready,
    output logic [47:0]       station_mac,
    output logic              irq
);
    logic                          mem_we;
    logic [31:0]                   mem_rdata;
    logic [BUF_AW:0]               st_raddr;
    logic [31:0]                   st_rdata;
    logic [31:0]                   mac_w0;
    logic [15:0]                   mac_w1;
    logic [NUM_BUF-1:0]            pend_set;
    logic [NUM_BUF-1:0]            busy;
    logic [NUM_BUF-1:0][LEN_W-1:0] len_q;
    logic                          tx_done;
    logic                          done_buf;

    eth_tx_bufmem #(.BUF_AW(BUF_AW)) u_mem (
        .clk         (clk),
        .we          (mem_we),
        .waddr       (bus_addr),
        .wdata       (bus_wdata),
        .bus_raddr   (bus_addr),
        .bus_rdata_w (mem_rdata),
        .st_raddr    (st_raddr),
        .st_rdata    (st_rdata),
        .mac_sel     (bus_addr[BUF_AW]),
        .mac_w0      (mac_w0),
        .mac_w1      (mac_w1)
    );

    eth_tx_regs #(.BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .mem_we      (mem_we),
        .mem_rdata   (mem_rdata),
        .mac_w0      (mac_w0),
        .mac_w1      (mac_w1),
        .pend_set    (pend_set),
        .busy        (busy),
        .len_q       (len_q),
        .tx_done     (tx_done),
        .done_buf    (done_buf),
        .station_mac (station_mac),
        .irq         (irq)
    );

    eth_tx_stream #(.BUF_AW(BUF_AW), .LEN_W(LEN_W)) u_stream (
        .clk      (clk),
        .rst      (rst),
        .pend_set (pend_set),
        .len_q    (len_q),
        .busy     (busy),
        .st_raddr (st_raddr),
        .st_rdata (st_rdata),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_last  (tx_last),
        .tx_ready (tx_ready),
        .tx_done  (tx_done),
        .done_buf (done_buf)
    );

endmodule

// File: tb/tb_eth_tx_ctrl.sv
module tb_eth_tx_ctrl;

    localparam int A_LEN0  = 509;
    localparam int A_GIE   = 510;
    localparam int A_CTRL0 = 511;
    localparam int A_B1    = 512;
    localparam int A_LEN1  = 1021;
    localparam int A_HOLE  = 1022;
    localparam int A_CTRL1 = 1023;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data;
    logic        tx_valid;
    logic        tx_last;
    logic        tx_ready = 1'b0;
    logic [47:0] station_mac;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int irq_cnt = 0;
    int cap_n = 0;
    int ready_mode = 0;
    logic [7:0] cap_data [256];
    logic       cap_last [256];
    logic       hold_pend = 1'b0;
    logic [8:0] hold_val = '0;

    eth_tx_ctrl dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_last(tx_last), .tx_ready(tx_ready),
        .station_mac(station_mac), .irq(irq)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Sink ready pattern, changed just after each rising edge
    always @(posedge clk) begin
        #1;
        case (ready_mode)
            0:       tx_ready <= 1'b0;
            1:       tx_ready <= 1'b1;
            default: tx_ready <= ~tx_ready;
        endcase
    end

    // Monitor at the falling edge
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (hold_pend)
                check(tx_valid && ({tx_last, tx_data} == hold_val), "R5", "held byte",
                      {55'b0, tx_last, tx_data}, {55'b0, hold_val});
            hold_pend = tx_valid && !tx_ready;
            hold_val  = {tx_last, tx_data};
            if (tx_valid && tx_ready && cap_n < 256) begin
                cap_data[cap_n] = tx_data;
                cap_last[cap_n] = tx_last;
                cap_n++;
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 10'(a); bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 10'(a);
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_bytes(input int n);
        for (int i = 0; i < 2000 && cap_n < n; i++) @(negedge clk);
    endtask

    task automatic expect_bytes(input string req, input int n, input logic [7:0] exp [8],
                                input int last_a, input int last_b);
        check(cap_n == n, req, "byte count", 64'(cap_n), 64'(n));
        for (int i = 0; i < n && i < 8; i++) begin
            check(cap_data[i] == exp[i], req, "byte value", {56'b0, cap_data[i]}, {56'b0, exp[i]});
            check(cap_last[i] == ((i == last_a) || (i == last_b)), req, "last flag",
                  64'(cap_last[i]), 64'((i == last_a) || (i == last_b)));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check(station_mac == 48'h0, "R1", "station_mac", station_mac, 0);
        check(!irq && !tx_valid, "R1", "irq/tx_valid", {62'b0, irq, tx_valid}, 0);
        rd(A_CTRL0, d); check(d == 0, "R1", "ctrl0", d, 0);
        rd(A_CTRL1, d); check(d == 0, "R1", "ctrl1", d, 0);
        rd(A_LEN0, d);  check(d == 0, "R1", "len0", d, 0);
        rd(A_LEN1, d);  check(d == 0, "R1", "len1", d, 0);
        rd(A_GIE, d);   check(d == 0, "R1", "gie", d, 0);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr(A_GIE, 32'h8000_0001); rd(A_GIE, d); check(d == 32'h8000_0001, "R2", "gie rb", d, 32'h8000_0001);
        wr(A_HOLE, 32'hDEAD_BEEF); rd(A_HOLE, d); check(d == 0, "R2", "hole", d, 0);
        wr(100, 32'hCAFE_0123); rd(100, d); check(d == 32'hCAFE_0123, "R2", "data rb", d, 32'hCAFE_0123);
        wr(A_LEN1, 32'h1FF); rd(A_LEN1, d); check(d == 32'h1FF, "R2", "len rb", d, 32'h1FF);
        cap_n = 0;
        wr(A_CTRL0, 32'hF0F4); rd(A_CTRL0, d); check(d == 32'hF0F4, "R3", "store only", d, 32'hF0F4);
        wr(A_CTRL0, 32'h0000_000A); repeat (4) @(negedge clk);
        rd(A_CTRL0, d); check(d == 32'h8, "R3", "P alone stored, cleared", d, 32'h8);
        check(cap_n == 0, "R3", "P alone sends nothing", 64'(cap_n), 0);
        check(station_mac == 0, "R3", "P alone keeps mac", station_mac, 0);
        wr(A_GIE, 32'h8000_0000);
    endtask

    task automatic t_send();
        logic [31:0] d;
        int i0;
        logic [7:0] exp [8] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77, 8'h00};
        wr(0, 32'h4433_2211); wr(1, 32'h8877_6655); wr(A_LEN0, 7);
        ready_mode = 0; cap_n = 0; i0 = irq_cnt;
        wr(A_CTRL0, 32'h9);
        repeat (3) @(negedge clk);
        check(tx_valid && tx_data == 8'h11, "R4", "first byte waits", {55'b0, tx_valid, tx_data}, {55'b0, 1'b1, 8'h11});
        rd(A_CTRL0, d); check(d == 32'h9, "R7", "S while sending", d, 32'h9);
        wr(A_CTRL0, 32'h3); repeat (2) @(negedge clk);
        rd(A_CTRL0, d); check(d == 32'h9, "R8", "busy ctrl unchanged", d, 32'h9);
        check(station_mac == 0, "R8", "busy load ignored", station_mac, 0);
        ready_mode = 2;
        wait_bytes(7); repeat (6) @(negedge clk);
        expect_bytes("R4", 7, exp, 6, 6);
        check(irq_cnt - i0 == 1, "R10", "send irq", 64'(irq_cnt - i0), 1);
        rd(A_CTRL0, d); check(d == 32'h8, "R7", "S cleared", d, 32'h8);
        check(cap_n == 7, "R8", "no extra frame", 64'(cap_n), 7);
        ready_mode = 0;
    endtask

    task automatic t_prog();
        logic [31:0] d;
        int i0;
        wr(A_B1, 32'hDDCC_BBAA); wr(A_B1 + 1, 32'h1234_FFEE);
        cap_n = 0; i0 = irq_cnt;
        wr(A_CTRL1, 32'hB); repeat (2) @(negedge clk);
        check(station_mac == 48'hFFEE_DDCC_BBAA, "R6", "mac loaded", station_mac, 48'hFFEE_DDCC_BBAA);
        check(cap_n == 0, "R6", "no frame", 64'(cap_n), 0);
        check(irq_cnt - i0 == 1, "R10", "load irq", 64'(irq_cnt - i0), 1);
        rd(A_CTRL1, d); check(d == 32'h8, "R7", "P,S cleared", d, 32'h8);
    endtask

    task automatic t_zero();
        logic [31:0] d;
        int i0;
        wr(A_LEN0, 0); cap_n = 0; i0 = irq_cnt;
        wr(A_CTRL0, 32'h9); repeat (4) @(negedge clk);
        check(cap_n == 0, "R9", "zero length no bytes", 64'(cap_n), 0);
        check(irq_cnt - i0 == 1, "R9", "zero length irq", 64'(irq_cnt - i0), 1);
        rd(A_CTRL0, d); check(d == 32'h8, "R9", "zero length S", d, 32'h8);
    endtask

    task automatic t_irq_gate();
        int i0;
        logic [7:0] exp [8] = '{8'hAA, 8'hBB, 8'hCC, 8'hDD, 8'h0, 8'h0, 8'h0, 8'h0};
        wr(A_GIE, 0); i0 = irq_cnt;
        wr(A_CTRL1, 32'hB); repeat (3) @(negedge clk);
        check(irq_cnt - i0 == 0, "R10", "gie off", 64'(irq_cnt - i0), 0);
        wr(A_GIE, 32'h8000_0000); wr(A_LEN1, 4);
        ready_mode = 1; cap_n = 0; i0 = irq_cnt;
        wr(A_CTRL1, 32'h1);
        wait_bytes(4); repeat (4) @(negedge clk);
        expect_bytes("R4", 4, exp, 3, 3);
        check(irq_cnt - i0 == 0, "R10", "I clear", 64'(irq_cnt - i0), 0);
        ready_mode = 0;
    endtask

    task automatic t_pair();
        logic [31:0] d;
        logic [7:0] exp [8] = '{8'h09, 8'h0A, 8'h0B, 8'h1B, 8'h1C, 8'h0, 8'h0, 8'h0};
        wr(0, 32'h0C0B_0A09); wr(A_LEN0, 3);
        wr(A_B1, 32'h1E1D_1C1B); wr(A_LEN1, 2);
        ready_mode = 0; cap_n = 0;
        wr(A_CTRL0, 32'h1); wr(A_CTRL1, 32'h1);
        rd(A_CTRL1, d); check(d == 32'h1, "R11", "queued S", d, 32'h1);
        ready_mode = 1;
        wait_bytes(5); repeat (4) @(negedge clk);
        expect_bytes("R11", 5, exp, 2, 4);
        rd(A_CTRL1, d); check(d == 32'h0, "R11", "queued done", d, 32'h0);
        ready_mode = 0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_send();
        t_prog();
        t_zero();
        t_irq_gate();
        t_pair();
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule